// File: doc/BRIEF.md
# Address Break Comparator Channel

One channel of a bus watchpoint unit. It watches every valid bus cycle. It raises a break when two things are true at once: the access address equals a programmed 24-bit break address, and the cycle is of a selected type. A programmable number of low address bits can be left out of the compare. A hit sets a sticky status flag. The flag stays set until software clears it. An interrupt request follows the flag whenever the channel's interrupt enable is on.

Software reaches the channel through a small register port. Select 0 holds the break address. Select 1 holds the control byte: the mask code, the cycle condition and the interrupt enable. Select 2 holds the status flag. Register reads are combinational.

The flag is held by a two-state machine.
- `FLAG_CLR` moves to `FLAG_SET` on the transition *hit*, which is a qualifying bus cycle.
- `FLAG_SET` moves back to `FLAG_CLR` on the transition *clear*, which is a status write with bit 0 at 0 in a cycle that has no hit.
- In every other case the state holds (*hold*).

Top module: `addr_break_chan`

## Requirements
- R1: Select 0 stores the 24-bit break address. It reads back what was written and resets to 0.
- R2: Select 1 is the control byte, and it resets to 0.
  - Bits 5:3 hold the mask code.
  - Bits 2:1 hold the condition.
  - Bit 0 holds the interrupt enable.
  - Reads return the stored fields, and every other bit reads 0.
- R3: The mask code sets how many low address bits the compare ignores. Codes 0 to 7 ignore 0, 1, 2, 3, 4, 8, 12 and 16 bits. Code 0 compares all 24 bits.
- R4: Condition 00 matches only cycles with `bus_fetch` = 1.
- R5: The other conditions match only cycles with `bus_fetch` = 0.
  - Condition 01 matches reads (`bus_write` = 0).
  - Condition 10 matches writes (`bus_write` = 1).
  - Condition 11 matches either direction.
- R6: A cycle with `bus_valid` = 0 never matches.
- R7: A qualifying cycle sets `brk_flag` from the next clock edge. The flag then stays set.
- R8: Writing select 2 with bit 0 at 0 clears the flag. Writing it with bit 0 at 1 has no effect. Select 2 reads the flag in bit 0.
- R9: When a hit and a clearing write fall in the same cycle, the flag ends set.
- R10: `brk_irq` is high exactly when `brk_flag` and the interrupt enable are both 1.
- R11: A register write affects only bus cycles after the write edge. A bus cycle in the same cycle as the write is compared against the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 control, 2 status |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data of the selected register |
| bus_addr | input | 24 | Monitored bus address |
| bus_valid | input | 1 | Bus cycle valid |
| bus_fetch | input | 1 | Cycle is an instruction fetch |
| bus_write | input | 1 | Data cycle direction, 1 = write |
| brk_flag | output | 1 | Sticky break status |
| brk_irq | output | 1 | Break interrupt request |

## Verification
Two events can land on the same edge.
- A matching bus cycle and a software clear of the flag (R9). The bench drives a hit together with a status write of 0 while the flag is already set. It expects the flag to stay set.
- A register rewrite and a bus cycle that matches only the old settings (R11). The bench writes a new address during an access to the old one. It expects the flag to be set, and expects a later access to the old address not to hit.

Random stimulus mixes writes and bus cycles freely, so both collisions also occur by chance. Every edge is judged against a reference model that applies the pre-edge register values and gives the set priority over the clear.

// File: rtl/abc_pkg.sv
package abc_pkg;

    localparam int ADDR_W  = 24;
    localparam int CTRL_W  = 8;
    localparam int MCODE_W = 3;

    typedef enum logic [1:0] {
        COND_FETCH = 2'b00,
        COND_READ  = 2'b01,
        COND_WRITE = 2'b10,
        COND_DATA  = 2'b11
    } cond_e;

    typedef enum logic {
        FLAG_CLR = 1'b0,
        FLAG_SET = 1'b1
    } flag_state_e;

    localparam logic [1:0] SEL_ADDR   = 2'd0;
    localparam logic [1:0] SEL_CTRL   = 2'd1;
    localparam logic [1:0] SEL_STATUS = 2'd2;

    // Number of low address bits left out of the compare for each mask code.
    function automatic logic [4:0] masked_bits(input logic [MCODE_W-1:0] code);
        logic [4:0] n;
        unique case (code)
            3'd0:    n = 5'd0;
            3'd1:    n = 5'd1;
            3'd2:    n = 5'd2;
            3'd3:    n = 5'd3;
            3'd4:    n = 5'd4;
            3'd5:    n = 5'd8;
            3'd6:    n = 5'd12;
            default: n = 5'd16;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import abc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [1:0]         sel,
    input  logic [AW-1:0]      wdata,
    input  logic               flag,
    output logic [AW-1:0]      brk_addr,
    output logic [MCODE_W-1:0] mask_code,
    output cond_e              cond,
    output logic               ie,
    output logic               clr_req,
    output logic [AW-1:0]      rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_addr  <= '0;
            mask_code <= '0;
            cond      <= COND_FETCH;
            ie        <= 1'b0;
        end else if (wr) begin
            if (sel == SEL_ADDR) begin
                brk_addr <= wdata;
            end
            if (sel == SEL_CTRL) begin
                mask_code <= wdata[5:3];
                cond      <= cond_e'(wdata[2:1]);
                ie        <= wdata[0];
            end
        end
    end

    assign clr_req = wr && (sel == SEL_STATUS) && !wdata[0];

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_ADDR:   rdata = brk_addr;
            SEL_CTRL:   rdata[5:0] = {mask_code, cond, ie};
            SEL_STATUS: rdata[0] = flag;
            default:    rdata = '0;
        endcase
    end

    // R2: an enable bit that is off cannot come back on without a control write.
    assert_ie_write_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie && !(wr && sel == SEL_CTRL)) |=> !ie);

endmodule

// File: rtl/brk_matcher.sv
module brk_matcher
    import abc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      brk_addr,
    input  logic [MCODE_W-1:0] mask_code,
    input  cond_e              cond,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_valid,
    input  logic               bus_fetch,
    input  logic               bus_write,
    output logic               hit
);

    logic [4:0]    ign_cnt;
    logic [AW-1:0] bit_ok;
    logic          addr_ok;
    logic          type_ok;

    assign ign_cnt = masked_bits(mask_code);

    for (genvar i = 0; i < AW; i++) begin : g_bitcmp
        assign bit_ok[i] = (brk_addr[i] == bus_addr[i]) || (i < int'(ign_cnt));
    end

    assign addr_ok = &bit_ok;

    always_comb begin
        unique case (cond)
            COND_FETCH: type_ok = bus_fetch;
            COND_READ:  type_ok = !bus_fetch && !bus_write;
            COND_WRITE: type_ok = !bus_fetch && bus_write;
            COND_DATA:  type_ok = !bus_fetch;
            default:    type_ok = 1'b0;
        endcase
    end

    assign hit = bus_valid && addr_ok && type_ok;

    // R4: a fetch-condition hit needs a fetch cycle.
    assert_fetch_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cond == COND_FETCH) |-> bus_fetch);
    // R5: a data-condition hit never comes from a fetch cycle.
    assert_data_no_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cond != COND_FETCH) |-> !bus_fetch);
    // R6: no hit without a valid cycle.
    assert_valid_needed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> bus_valid);
    // R3: code 0 needs an exact address on every hit.
    assert_full_compare_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mask_code == 3'd0) |-> (bus_addr == brk_addr));

endmodule

// File: rtl/brk_flag_fsm.sv
module brk_flag_fsm
    import abc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr_req,
    output logic flag
);

    flag_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            FLAG_CLR: if (hit) state_nx = FLAG_SET;
            FLAG_SET: if (clr_req && !hit) state_nx = FLAG_CLR;
            default:  state_nx = FLAG_CLR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLAG_CLR;
        else        state <= state_nx;
    end

    always_comb begin
        flag = (state == FLAG_SET);
    end

    // R7: a hit is seen on the flag after the edge.
    assert_set_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    // R7: the flag holds without a clearing write.
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
    // R8: a clearing write without a hit drops the flag.
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !hit) |=> !flag);
    // R9: set wins over clear.
    assert_set_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && hit) |=> flag);

endmodule

// File: rtl/addr_break_chan.sv
module addr_break_chan
    import abc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_valid,
    input  logic          bus_fetch,
    input  logic          bus_write,
    output logic          brk_flag,
    output logic          brk_irq
);

    logic [AW-1:0]      ba;
    logic [MCODE_W-1:0] mcode;
    cond_e              cond;
    logic               ie;
    logic               clr_req;
    logic               hit;

    brk_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .flag      (brk_flag),
        .brk_addr  (ba),
        .mask_code (mcode),
        .cond      (cond),
        .ie        (ie),
        .clr_req   (clr_req),
        .rdata     (reg_rdata)
    );

    brk_matcher #(.AW(AW)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_addr  (ba),
        .mask_code (mcode),
        .cond      (cond),
        .bus_addr  (bus_addr),
        .bus_valid (bus_valid),
        .bus_fetch (bus_fetch),
        .bus_write (bus_write),
        .hit       (hit)
    );

    brk_flag_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr_req (clr_req),
        .flag    (brk_flag)
    );

    assign brk_irq = brk_flag && ie;

    // R10: the request never rises while interrupts are disabled.
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !brk_irq);
    // R10: the request needs the sticky flag.
    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq |-> brk_flag);

endmodule

// File: tb/test_addr_break_chan.sv
module test_addr_break_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic [23:0] bus_addr = '0;
    logic        bus_valid = 1'b0;
    logic        bus_fetch = 1'b0;
    logic        bus_write = 1'b0;
    logic        brk_flag;
    logic        brk_irq;

    int checks = 0;
    int errors = 0;

    logic [23:0] m_ba   = '0;
    logic [5:0]  m_ctrl = '0;
    logic        m_flag = 1'b0;

    always #4 clk = ~clk;

    addr_break_chan i_addr_break_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .bus_addr  (bus_addr),
        .bus_valid (bus_valid),
        .bus_fetch (bus_fetch),
        .bus_write (bus_write),
        .brk_flag  (brk_flag),
        .brk_irq   (brk_irq)
    );

    function automatic int ign(input logic [2:0] code);
        case (code)
            3'd5: return 8;
            3'd6: return 12;
            3'd7: return 16;
            default: return int'(code);
        endcase
    endfunction

    function automatic logic model_hit(input logic [23:0] ba, input logic [5:0] ctrl,
                                       input logic [23:0] a, input logic v,
                                       input logic f, input logic w);
        logic tok;
        case (ctrl[2:1])
            2'b00: tok = f;
            2'b01: tok = !f && !w;
            2'b10: tok = !f && w;
            default: tok = !f;
        endcase
        return v && tok && (((ba ^ a) >> ign(ctrl[5:3])) == 24'd0);
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one cycle at a falling edge, updates the model at the rising edge,
    // and checks the outputs at the next falling edge.
    task automatic step(input string req, input logic wr, input logic [1:0] sel,
                        input logic [23:0] wd, input logic [23:0] a,
                        input logic v, input logic f, input logic w);
        logic h;
        logic clr;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        bus_addr = a; bus_valid = v; bus_fetch = f; bus_write = w;
        h   = model_hit(m_ba, m_ctrl, a, v, f, w);
        clr = wr && sel == 2'd2 && !wd[0];
        @(posedge clk);
        m_flag = h || (m_flag && !clr);
        if (wr && sel == 2'd0) m_ba = wd;
        if (wr && sel == 2'd1) m_ctrl = wd[5:0];
        @(negedge clk);
        reg_wr = 1'b0; bus_valid = 1'b0;
        check(req, {23'd0, brk_flag}, {23'd0, m_flag});
        check("R10", {23'd0, brk_irq}, {23'd0, m_flag && m_ctrl[0]});
    endtask

    task automatic rd(input string req, input logic [1:0] sel, input logic [23:0] exp);
        reg_wr = 1'b0; reg_sel = sel;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic idle_step(input string req);
        step(req, 1'b0, 2'd3, 24'd0, 24'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic wr_reg(input string req, input logic [1:0] sel, input logic [23:0] d);
        step(req, 1'b1, sel, d, 24'd0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check("R1", reg_rdata, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", {23'd0, brk_flag}, 24'd0);
        check("R10", {23'd0, brk_irq}, 24'd0);
        rd("R1", 2'd0, 24'd0);
        rd("R2", 2'd1, 24'd0);
        rd("R8", 2'd2, 24'd0);

        // R1 / R2 readback
        wr_reg("R1", 2'd0, 24'hABCDEF);
        rd("R1", 2'd0, 24'hABCDEF);
        wr_reg("R2", 2'd1, 24'hFFFFFF);
        rd("R2", 2'd1, 24'h00003F);

        // R3: every mask code, one bit inside and one just outside the mask
        for (int c = 0; c < 8; c++) begin
            int n;
            n = ign(3'(c));
            wr_reg("R3", 2'd1, {18'd0, 3'(c), 2'b00, 1'b1});
            wr_reg("R8", 2'd2, 24'd0);
            if (n > 0) begin
                step("R3", 1'b0, 2'd3, 0, m_ba ^ (24'd1 << (n - 1)), 1'b1, 1'b1, 1'b0);
                check("R3", {23'd0, brk_flag}, 24'd1);
                wr_reg("R8", 2'd2, 24'd0);
            end
            step("R3", 1'b0, 2'd3, 0, m_ba ^ (24'd1 << n), 1'b1, 1'b1, 1'b0);
            check("R3", {23'd0, brk_flag}, 24'd0);
        end

        // R4/R5: condition qualification, exact address
        wr_reg("R5", 2'd1, {18'd0, 3'd0, 2'b01, 1'b1});
        step("R5", 1'b0, 2'd3, 0, m_ba, 1'b1, 1'b1, 1'b0);
        check("R5", {23'd0, brk_flag}, 24'd0);
        step("R5", 1'b0, 2'd3, 0, m_ba, 1'b1, 1'b0, 1'b1);
        check("R5", {23'd0, brk_flag}, 24'd0);
        step("R5", 1'b0, 2'd3, 0, m_ba, 1'b1, 1'b0, 1'b0);
        check("R5", {23'd0, brk_flag}, 24'd1);
        wr_reg("R8", 2'd2, 24'd0);
        wr_reg("R4", 2'd1, {18'd0, 3'd0, 2'b00, 1'b0});
        step("R4", 1'b0, 2'd3, 0, m_ba, 1'b1, 1'b0, 1'b0);
        check("R4", {23'd0, brk_flag}, 24'd0);
        step("R6", 1'b0, 2'd3, 0, m_ba, 1'b0, 1'b1, 1'b0);
        check("R6", {23'd0, brk_flag}, 24'd0);
        step("R4", 1'b0, 2'd3, 0, m_ba, 1'b1, 1'b1, 1'b0);
        check("R10", {23'd0, brk_irq}, 24'd0);

        // R8: writing 1 keeps the flag; writing 0 clears it
        wr_reg("R8", 2'd2, 24'd1);
        rd("R8", 2'd2, 24'd1);
        idle_step("R7");
        rd("R8", 2'd2, 24'd1);
        wr_reg("R8", 2'd2, 24'd0);
        rd("R8", 2'd2, 24'd0);

        // R9: hit and clear in one cycle
        step("R9", 1'b0, 2'd3, 0, m_ba, 1'b1, 1'b1, 1'b0);
        step("R9", 1'b1, 2'd2, 24'd0, m_ba, 1'b1, 1'b1, 1'b0);
        check("R9", {23'd0, brk_flag}, 24'd1);
        wr_reg("R8", 2'd2, 24'd0);

        // R11: rewrite the address during an access to the old one
        begin
            logic [23:0] old_ba;
            old_ba = m_ba;
            step("R11", 1'b1, 2'd0, old_ba ^ 24'h800000, old_ba, 1'b1, 1'b1, 1'b0);
            check("R11", {23'd0, brk_flag}, 24'd1);
            wr_reg("R8", 2'd2, 24'd0);
            step("R11", 1'b0, 2'd3, 0, old_ba, 1'b1, 1'b1, 1'b0);
            check("R11", {23'd0, brk_flag}, 24'd0);
        end

        // Random mix
        for (int k = 0; k < 4000; k++) begin
            logic        wr;
            logic [1:0]  sel;
            logic [23:0] wd;
            logic [23:0] a;
            wr  = ($urandom % 5) == 0;
            sel = 2'($urandom % 3);
            wd  = 24'($urandom);
            if (sel == 2'd2) wd[0] = ($urandom % 4) == 0;
            a = m_ba;
            if (($urandom % 3) == 0) a = a ^ (24'd1 << ($urandom % 24));
            step("R7", wr, sel, wd, a, ($urandom % 4) != 0, 1'($urandom), 1'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule